// File: doc/BRIEF.md
# Interleaved Byte-Bank Data Memory

This block is the data store of a 32-bit load/store datapath. Storage is split into four banks, each one byte wide. Byte address A sits in bank A mod 4, at row A div 4. Each bank has its own row index, so a word or half-word that starts at any byte address reaches all of its bytes in the same cycle. A misaligned access costs no more time than an aligned one.

An access that crosses a row boundary moves its upper bytes into the next row. An access that runs past the highest address continues from address 0. Reads are combinational and always return a full 32-bit little-endian word. Any narrowing or sign extension for sub-word loads is left to the logic that consumes the word.

The interface is plain and has no handshake. An address, a write enable, a size code and write data are presented each cycle. The block accepts every cycle and never stalls, so there is no back-pressure to honour. `DEPTH` is the number of 32-bit rows and must be a power of two.

Top module: `ibdm_top`

## Requirements
- R1: A word write (size code 2'b10, or 2'b11 treated the same) at an address with offset 0 stores wr_data[7:0] at A, [15:8] at A+1, [23:16] at A+2 and [31:24] at A+3. A read of A returns the byte at A in bits 7:0 and the following bytes in ascending lanes.
- R2: A word write at an address whose offset (A mod 4) is non-zero completes in the same single cycle. Its bytes past the row end go to the next row, and a read at that address returns the same word.
- R3: A half-word write (size code 2'b01) updates only bytes A and A+1, with wr_data[7:0] at A. All other bytes keep their values.
- R4: A byte write (size code 2'b00) updates only byte A with wr_data[7:0]. All other bytes keep their values.
- R5: Any write or read whose bytes extend past the highest byte address wraps to address 0 and continues upward.
- R6: The read path is combinational from the present address. Before the clock edge of a write, a read shows the old contents. From the cycle after that edge, it shows the new data.
- R7: While rst_n is low, every byte of storage is cleared to zero.
- R8: With wr_en low, a clock edge changes no stored byte, whatever the address, size and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Active-low reset; clears all storage |
| addr | input | ADDR_W ($clog2(DEPTH)+2) | Byte address for both read and write |
| wr_en | input | 1 | Write request for this cycle |
| wr_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| wr_data | input | 32 | Write data, byte for address A in bits 7:0 |
| rd_data | output | 32 | Word assembled from bytes A..A+3, little-endian |

## Verification
A small 16-row instance is driven through every byte address with each of the three write sizes. A byte-array model predicts the result. Word writes at offsets 1 to 3 separate correct row spill from writes that stay in one row. Writes at the last three addresses expose any failure to wrap to address 0. After each write, the words four bytes below and four bytes above the target are read back, which shows whether a half-word or byte write disturbed its neighbours. Further passes cover the combinational read before the edge, writes with the enable low, and reset clearing data that is already stored.

// File: rtl/ibdm_pkg.sv
package ibdm_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  // number of bytes touched by a write of the given size
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    unique case (acc_size_e'(sz))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ibdm_lane_map.sv
module ibdm_lane_map
  import ibdm_pkg::*;
#(
  parameter int unsigned ROW_W = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ROW_W+1:0]                  addr_i,
  input  logic                              wr_en_i,
  input  logic [1:0]                        wr_size_i,
  input  logic [WORD_W-1:0]                 wr_data_i,
  output logic [LANES-1:0][ROW_W-1:0]       bank_row_o,
  output logic [LANES-1:0]                  bank_we_o,
  output logic [LANES-1:0][LANE_W-1:0]      bank_wdata_o
);

  logic [1:0]       offset;
  logic [ROW_W-1:0] base_row;
  logic [ROW_W-1:0] next_row;
  logic [2:0]       nbytes;

  assign offset   = addr_i[1:0];
  assign base_row = addr_i[ROW_W+1:2];
  assign next_row = base_row + ROW_W'(1);   // wraps at the top row
  assign nbytes   = size_bytes(wr_size_i);

  // bank b holds byte position (b - offset) mod 4 of the access
  always_comb begin
    for (int b = 0; b < int'(LANES); b++) begin
      logic [1:0] pos;
      pos             = 2'(b) - offset;
      bank_row_o[b]   = (2'(b) < offset) ? next_row : base_row;
      bank_we_o[b]    = wr_en_i && ({1'b0, pos} < nbytes);
      bank_wdata_o[b] = wr_data_i[pos*LANE_W +: LANE_W];
    end
  end

  // the number of enabled banks matches the size code
  assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> ($countones(bank_we_o) ==
                 ((wr_size_i == 2'b00) ? 1 : (wr_size_i == 2'b01) ? 2 : 4)));

  // the bank holding byte A itself is always written
  assert_first_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> bank_we_o[offset]);

  // no write enable leaves every bank idle
  assert_idle_banks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |-> (bank_we_o == '0));

  // the highest bank never spills into the next row
  assert_top_bank_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_row_o[LANES-1] == addr_i[ROW_W+1:2]);

endmodule

// File: rtl/ibdm_byte_bank.sv
module ibdm_byte_bank
  import ibdm_pkg::*;
#(
  parameter int unsigned ROWS  = 1024,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);

  logic [LANE_W-1:0] store [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ROWS); r++) store[r] <= '0;
    end else if (we_i) begin
      store[row_i] <= wdata_i;
    end
  end

  assign rdata_o = store[row_i];

  // a written byte holds the new value one cycle later
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (store[$past(row_i)] == $past(wdata_i)));

  // without a write the addressed byte keeps its value
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> (store[$past(row_i)] == $past(store[row_i])));

endmodule

// File: rtl/ibdm_read_rotate.sv
module ibdm_read_rotate
  import ibdm_pkg::*;
(
  input  logic [1:0]                   offset_i,
  input  logic [LANES-1:0][LANE_W-1:0] bank_rdata_i,
  output logic [WORD_W-1:0]            rd_data_o
);

  // output lane k carries the byte at A + k, held in bank (offset + k) mod 4
  always_comb begin
    for (int k = 0; k < int'(LANES); k++) begin
      logic [1:0] src;
      src = 2'(k) + offset_i;
      rd_data_o[k*LANE_W +: LANE_W] = bank_rdata_i[src];
    end
  end

endmodule

// File: rtl/ibdm_top.sv
module ibdm_top
  import ibdm_pkg::*;
#(
  parameter  int unsigned DEPTH  = 1024,
  localparam int unsigned ROW_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = ROW_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);

  logic [LANES-1:0][ROW_W-1:0]  bank_row;
  logic [LANES-1:0]             bank_we;
  logic [LANES-1:0][LANE_W-1:0] bank_wdata;
  logic [LANES-1:0][LANE_W-1:0] bank_rdata;

  ibdm_lane_map #(.ROW_W(ROW_W)) u_map (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr),
    .wr_en_i      (wr_en),
    .wr_size_i    (wr_size),
    .wr_data_i    (wr_data),
    .bank_row_o   (bank_row),
    .bank_we_o    (bank_we),
    .bank_wdata_o (bank_wdata)
  );

  for (genvar b = 0; b < int'(LANES); b++) begin : g_bank
    ibdm_byte_bank #(.ROWS(DEPTH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bank_we[b]),
      .row_i   (bank_row[b]),
      .wdata_i (bank_wdata[b]),
      .rdata_o (bank_rdata[b])
    );
  end

  ibdm_read_rotate u_rot (
    .offset_i     (addr[1:0]),
    .bank_rdata_i (bank_rdata),
    .rd_data_o    (rd_data)
  );

  // an aligned read is the banks in their natural order
  assert_aligned_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] == 2'b00) |-> (rd_data == {bank_rdata[3], bank_rdata[2],
                                          bank_rdata[1], bank_rdata[0]}));

  // the low byte of the result always comes from the bank holding A
  assert_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:0] == bank_rdata[addr[1:0]]);

endmodule

// File: tb/test_ibdm_top.sv
module test_ibdm_top;

  localparam int DEPTH  = 16;
  localparam int NBYTES = DEPTH * 4;
  localparam int AW     = $clog2(DEPTH) + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_size = 2'b00;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] model_mem [NBYTES];

  always #5 clk = ~clk;   // 100 MHz

  ibdm_top #(.DEPTH(DEPTH)) i_ibdm_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_size(wr_size), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [31:0] model_word(input int a);
    model_word = {model_mem[(a + 3) % NBYTES], model_mem[(a + 2) % NBYTES],
                  model_mem[(a + 1) % NBYTES], model_mem[a % NBYTES]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  // set address at a falling edge and compare the combinational word
  task automatic read_check(input string tag, input int a);
    @(negedge clk);
    addr = AW'(a);
    #1 check(tag, rd_data, model_word(a));
  endtask

  task automatic do_write(input string tag, input int a, input logic [1:0] sz,
                          input logic [31:0] d);
    int n;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    @(negedge clk);
    addr = AW'(a); wr_size = sz; wr_data = d; wr_en = 1'b1;
    #1 check("R6 pre-edge", rd_data, model_word(a));
    for (int i = 0; i < n; i++) model_mem[(a + i) % NBYTES] = d[8*i +: 8];
    @(negedge clk);
    wr_en = 1'b0;
    #1 check(tag, rd_data, model_word(a));
    read_check(tag, (a + NBYTES - 4) % NBYTES);
    read_check(tag, (a + 4) % NBYTES);
  endtask

  task automatic full_scan(input string tag);
    for (int a = 0; a < NBYTES; a++) read_check(tag, a);
  endtask

  initial begin
    for (int i = 0; i < NBYTES; i++) model_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    full_scan("R7 reset");

    for (int pass = 0; pass < 3; pass++) begin
      for (int a = 0; a < NBYTES; a++) begin
        logic [1:0]  sz;
        logic [31:0] d;
        string       tag;
        int          n;
        sz = (pass == 0) ? 2'b10 : (pass == 1) ? 2'b01 : 2'b00;
        n  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        d  = (32'h9E37_79B9 * (a + 1)) ^ (32'h5A3C_0F11 * (pass + 1));
        if (a + n > NBYTES)         tag = "R5 wrap";
        else if (sz == 2'b00)       tag = "R4 byte";
        else if (sz == 2'b01)       tag = "R3 half";
        else if (a % 4 != 0)        tag = "R2 misaligned";
        else                        tag = "R1 aligned";
        do_write(tag, a, sz, d);
      end
      full_scan("R5 scan");
    end

    // size code 2'b11 behaves as a word
    do_write("R1 alt size", 8, 2'b11, 32'hCAFE_F00D);
    do_write("R2 alt size", 63, 2'b11, 32'h0BAD_BEEF);

    // enable low: nothing changes at any address or size
    for (int a = 0; a < NBYTES; a += 5) begin
      @(negedge clk);
      addr = AW'(a); wr_size = 2'(a % 4); wr_data = ~model_word(a); wr_en = 1'b0;
      @(negedge clk);
      #1 check("R8 no enable", rd_data, model_word(a));
    end
    full_scan("R8 scan");

    // reset clears stored data
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < NBYTES; i++) model_mem[i] = 8'h00;
    @(negedge clk) rst_n = 1'b1;
    full_scan("R7 reclear");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule